// File: doc/BRIEF.md
# Boot Vector Sequencer

This block is the reset controller of a CPU core with a 16-bit data bus. It watches a pair of external reset inputs, decides whether a request is a real reset, and then runs the startup sequence. That sequence waits a short start-up time, then makes four word reads from the bottom of memory to load the initial supervisor stack pointer and the program counter. At the end it raises the interrupt mask to its top level and clears the vector base register. After that it releases the core by pulsing a done strobe.

The block also serves a software reset command from the running core. This command drives the system reset line outward for a fixed number of clocks and leaves every internal register as it was. A bus error on any of the four vector reads counts as a double fault. The block then parks the core in a halted state, and only a new qualified external reset gets it out. The bus is modelled as a plain request/acknowledge port: the block holds a request with a word address until the bus answers with either an acknowledge carrying read data or an error.

Top module: `boot_vector_seq`

## Requirements
- R1: An external reset is only considered while `ext_rst_i` and `ext_halt_i` are both high in the same cycle. `ext_rst_i` alone, held for any length of time, causes no bus request and changes no output.
- R2: A joint assertion sampled on 10 (MIN_HOLD) or more consecutive rising edges restarts the sequence once both inputs drop. A joint assertion of 9 edges or fewer is ignored, and in that case a halted core stays halted.
- R3: The vector reads go to byte addresses 0x0, 0x2, 0x4 and 0x6, in that order and with no others. Each request holds `bus_req_o` high with a stable address until `bus_ack_i` or `bus_err_i` is seen on a rising edge.
- R4: The words are big-endian. The stack pointer is {word at 0x0, word at 0x2} and the program counter is {word at 0x4, word at 0x6}. `ssp_o` and `pc_o` keep their old values until the fourth read completes.
- R5: On the edge that accepts the fourth acknowledge, `done_o` goes high for exactly one cycle. In the same cycle the new `ssp_o` and `pc_o` appear, `ipl_mask_o` reads 7 and `vbr_o` reads 0.
- R6: While the sequencer is idle, a `sw_rst_i` high on a rising edge makes `rst_out_o` high for exactly 124 (PULSE_CYC) clock periods, starting on that edge. `ssp_o`, `pc_o`, `ipl_mask_o` and `vbr_o` do not change.
- R7: `sw_rst_i` is ignored while the start-up wait or the vector reads are under way, while a pulse is already running, and while the core is halted.
- R8: After `rst_ni` is released, `bus_req_o` first goes high after the 4th (STARTUP_CYC) rising edge, and stays low before it.
- R9: A `bus_err_i` on a vector read sets `halted_o` on that edge. After that no further request is made and `ssp_o` and `pc_o` are unchanged. `halted_o` stays set until a qualified external reset.
- R10: A qualified external reset that lands during a software reset pulse ends the pulse. One that lands during the vector reads abandons them. Either way the sequence restarts from the start-up wait at address 0x0.
- R11: While `rst_ni` is low, `bus_req_o`, `rst_out_o`, `done_o` and `halted_o` are 0, `ssp_o`, `pc_o` and `vbr_o` are 0, and `ipl_mask_o` is 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| ext_rst_i | input | 1 | External reset request |
| ext_halt_i | input | 1 | External halt request, must accompany the reset |
| sw_rst_i | input | 1 | Software reset command from the core |
| bus_req_o | output | 1 | Vector read request |
| bus_addr_o | output | 24 | Byte address of the vector word |
| bus_rdata_i | input | 16 | Read data, valid with acknowledge |
| bus_ack_i | input | 1 | Read completed |
| bus_err_i | input | 1 | Read failed |
| rst_out_o | output | 1 | Outbound system reset pulse |
| done_o | output | 1 | One-cycle strobe when the startup sequence ends |
| ssp_o | output | 32 | Loaded supervisor stack pointer |
| pc_o | output | 32 | Loaded program counter |
| ipl_mask_o | output | 3 | Interrupt priority mask |
| vbr_o | output | 32 | Vector base register |
| halted_o | output | 1 | Core halted after a double fault |

## Verification
The sequence is started three ways: by releasing power-on reset, by a qualified external reset, and by a reset that lands in the middle of a fetch. Each run uses different vector words and bus latencies of zero, two and three cycles, so a swapped word order, a wrong endianness or a stale word shows up as a wrong pointer. A queue of expected addresses tells a restart at 0x0 apart from a fetch that just carries on. Reset pulses of 9 and 10 edges, and reset without halt, separate the qualification threshold from the AND of the two inputs. A software reset issued when idle, when busy, mid-pulse and when halted separates the exact 124-cycle pulse from a pulse that retriggers or is wrongly accepted.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_WAIT,
    ST_FETCH,
    ST_RUN,
    ST_HALT
  } boot_state_e;

  // Stack pointer high/low then program counter high/low.
  localparam int unsigned VEC_WORDS = 4;
  localparam int unsigned IPL_W     = 3;
  localparam logic [IPL_W-1:0] IPL_TOP = '1;
endpackage

// File: rtl/ext_rst_qual.sv
module ext_rst_qual #(
  parameter int unsigned MIN_HOLD = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_i,
  input  logic halt_i,
  output logic hold_o
);
  localparam int unsigned CW = $clog2(MIN_HOLD + 1);

  logic          both;
  logic [CW-1:0] cnt_q;

  assign both   = rst_i & halt_i;
  assign hold_o = (cnt_q == CW'(MIN_HOLD));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!both)           cnt_q <= '0;
    else if (!hold_o)         cnt_q <= cnt_q + 1'b1;
  end

  AST_QUAL_NEEDS_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_o) |-> $past(rst_i && halt_i)); // R1
  AST_QUAL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !both |=> !hold_o); // R2
endmodule

// File: rtl/rst_pulse_gen.sv
module rst_pulse_gen #(
  parameter int unsigned PULSE_CYC = 124
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic abort_i,
  output logic active_o
);
  localparam int unsigned CW = $clog2(PULSE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (abort_i) begin
      active_o <= 1'b0;
      cnt_q    <= '0;
    end else if (start_i && !active_o) begin
      active_o <= 1'b1;
      cnt_q    <= CW'(PULSE_CYC - 1);
    end else if (active_o) begin
      if (cnt_q == '0) active_o <= 1'b0;
      else             cnt_q    <= cnt_q - 1'b1;
    end
  end

  AST_PULSE_ABORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> !active_o); // R10
endmodule

// File: rtl/vec_fetch_seq.sv
module vec_fetch_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned STARTUP_CYC = 4
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  hold_i,
  input  logic                  sw_req_i,
  input  logic                  pulse_active_i,
  output logic                  pulse_start_o,
  output logic                  bus_req_o,
  output logic [ADDR_W-1:0]     bus_addr_o,
  input  logic [DATA_W-1:0]     bus_rdata_i,
  input  logic                  bus_ack_i,
  input  logic                  bus_err_i,
  output logic                  done_o,
  output logic [2*DATA_W-1:0]   ssp_o,
  output logic [2*DATA_W-1:0]   pc_o,
  output logic [IPL_W-1:0]      ipl_o,
  output logic [2*DATA_W-1:0]   vbr_o,
  output logic                  halted_o
);
  localparam int unsigned IDX_W = $clog2(VEC_WORDS);
  localparam int unsigned WCW   = $clog2(STARTUP_CYC + 1);

  boot_state_e          state_q;
  logic [WCW-1:0]       wcnt_q;
  logic [IDX_W-1:0]     idx_q;
  logic [DATA_W-1:0]    word_q [VEC_WORDS-1];
  logic                 take_word;
  logic                 last_word;

  assign bus_req_o     = (state_q == ST_FETCH);
  assign halted_o      = (state_q == ST_HALT);
  assign bus_addr_o    = ADDR_W'({idx_q, 1'b0});
  assign take_word     = bus_req_o && bus_ack_i && !bus_err_i && !hold_i;
  assign last_word     = (idx_q == IDX_W'(VEC_WORDS - 1));
  assign pulse_start_o = (state_q == ST_RUN) && sw_req_i && !pulse_active_i && !hold_i;

  // Capture registers for all words but the last, which commits straight from the bus.
  for (genvar g = 0; g < VEC_WORDS - 1; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                word_q[g] <= '0;
      else if (take_word && idx_q == IDX_W'(g))   word_q[g] <= bus_rdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT;
      wcnt_q  <= '0;
      idx_q   <= '0;
      done_o  <= 1'b0;
      ssp_o   <= '0;
      pc_o    <= '0;
      ipl_o   <= IPL_TOP;
      vbr_o   <= '0;
    end else begin
      done_o <= 1'b0;
      if (hold_i) begin
        state_q <= ST_HOLD;
        wcnt_q  <= '0;
        idx_q   <= '0;
      end else begin
        unique case (state_q)
          ST_HOLD: begin
            state_q <= ST_WAIT;
            wcnt_q  <= '0;
          end
          ST_WAIT: begin
            if (wcnt_q == WCW'(STARTUP_CYC - 1)) begin
              state_q <= ST_FETCH;
              idx_q   <= '0;
            end else begin
              wcnt_q <= wcnt_q + 1'b1;
            end
          end
          ST_FETCH: begin
            if (bus_err_i) begin
              state_q <= ST_HALT;
            end else if (bus_ack_i) begin
              if (last_word) begin
                ssp_o   <= {word_q[0], word_q[1]};
                pc_o    <= {word_q[2], bus_rdata_i};
                ipl_o   <= IPL_TOP;
                vbr_o   <= '0;
                done_o  <= 1'b1;
                state_q <= ST_RUN;
              end else begin
                idx_q <= idx_q + 1'b1;
              end
            end
          end
          ST_RUN:  state_q <= ST_RUN;
          ST_HALT: state_q <= ST_HALT;
          default: state_q <= ST_HALT;
        endcase
      end
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o && !bus_ack_i && !bus_err_i && !hold_i |=> bus_req_o && $stable(bus_addr_o)); // R3
  AST_ADDR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_req_o |-> (bus_addr_o < ADDR_W'(2 * VEC_WORDS)) && !bus_addr_o[0]); // R3
  AST_DONE_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(bus_req_o && bus_ack_i)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R5
  AST_SW_KEEPS_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_active_i |=> $stable(ssp_o) && $stable(pc_o) && $stable(vbr_o)); // R6
  AST_HALT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !hold_i |=> halted_o); // R9
  AST_HALT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o |-> !bus_req_o && !pulse_start_o); // R9
endmodule

// File: rtl/boot_vector_seq.sv
module boot_vector_seq
  import boot_seq_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned MIN_HOLD    = 10,
  parameter int unsigned STARTUP_CYC = 4,
  parameter int unsigned PULSE_CYC   = 124
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ext_rst_i,
  input  logic                ext_halt_i,
  input  logic                sw_rst_i,
  output logic                bus_req_o,
  output logic [ADDR_W-1:0]   bus_addr_o,
  input  logic [DATA_W-1:0]   bus_rdata_i,
  input  logic                bus_ack_i,
  input  logic                bus_err_i,
  output logic                rst_out_o,
  output logic                done_o,
  output logic [2*DATA_W-1:0] ssp_o,
  output logic [2*DATA_W-1:0] pc_o,
  output logic [IPL_W-1:0]    ipl_mask_o,
  output logic [2*DATA_W-1:0] vbr_o,
  output logic                halted_o
);
  logic hold;
  logic pulse_start;

  ext_rst_qual #(.MIN_HOLD(MIN_HOLD)) i_qual (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_i  (ext_rst_i),
    .halt_i (ext_halt_i),
    .hold_o (hold)
  );

  rst_pulse_gen #(.PULSE_CYC(PULSE_CYC)) i_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (pulse_start),
    .abort_i  (hold),
    .active_o (rst_out_o)
  );

  vec_fetch_seq #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .STARTUP_CYC (STARTUP_CYC)
  ) i_fetch (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .hold_i         (hold),
    .sw_req_i       (sw_rst_i),
    .pulse_active_i (rst_out_o),
    .pulse_start_o  (pulse_start),
    .bus_req_o      (bus_req_o),
    .bus_addr_o     (bus_addr_o),
    .bus_rdata_i    (bus_rdata_i),
    .bus_ack_i      (bus_ack_i),
    .bus_err_i      (bus_err_i),
    .done_o         (done_o),
    .ssp_o          (ssp_o),
    .pc_o           (pc_o),
    .ipl_o          (ipl_mask_o),
    .vbr_o          (vbr_o),
    .halted_o       (halted_o)
  );

  AST_PULSE_ONLY_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_out_o |-> !bus_req_o && !halted_o); // R7
endmodule

// File: tb/test_boot_vector_seq.sv
module test_boot_vector_seq;
  localparam time CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni, ext_rst, ext_halt, sw_rst;
  logic        bus_req, bus_ack, bus_err, rst_out, done, halted;
  logic [23:0] bus_addr;
  logic [15:0] bus_rdata;
  logic [31:0] ssp, pc, vbr;
  logic [2:0]  ipl;

  int n_chk = 0;
  int n_fail = 0;
  logic [15:0] mem [4];
  int lat = 0;
  int stall_at = -1;
  int err_at = -1;
  logic [23:0] exp_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_vector_seq i_boot_vector_seq (
    .clk_i(clk), .rst_ni(rst_ni), .ext_rst_i(ext_rst), .ext_halt_i(ext_halt),
    .sw_rst_i(sw_rst), .bus_req_o(bus_req), .bus_addr_o(bus_addr),
    .bus_rdata_i(bus_rdata), .bus_ack_i(bus_ack), .bus_err_i(bus_err),
    .rst_out_o(rst_out), .done_o(done), .ssp_o(ssp), .pc_o(pc),
    .ipl_mask_o(ipl), .vbr_o(vbr), .halted_o(halted)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic push_boot();
    for (int i = 0; i < 4; i++) exp_q.push_back(24'(2 * i));
  endtask

  task automatic ext_pulse(input int n, input bit with_halt);
    ext_rst  = 1'b1;
    ext_halt = with_halt;
    repeat (n) @(negedge clk);
    ext_rst  = 1'b0;
    ext_halt = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int k;
    for (k = 0; k < 3000 && !done; k++) @(negedge clk);
    chk({tag, " done strobe seen"}, done, 1'b1);
  endtask

  // Bus responder and monitor: pops an expected address on every completed read.
  initial begin
    int w;
    int idx;
    logic [23:0] e;
    w = 0;
    bus_ack = 1'b0;
    bus_err = 1'b0;
    bus_rdata = '0;
    forever begin
      @(negedge clk);
      if (bus_ack || bus_err) begin
        bus_ack = 1'b0;
        bus_err = 1'b0;
        w = 0;
      end else if (rst_ni && bus_req) begin
        idx = int'(bus_addr >> 1);
        if (idx == stall_at) begin
          w = 0;
        end else if (w < lat) begin
          w++;
        end else begin
          if (exp_q.size() == 0) begin
            chk("R3 unexpected read", bus_addr, 24'hffffff);
          end else begin
            e = exp_q.pop_front();
            chk("R3 read address order", bus_addr, e);
          end
          bus_rdata = mem[idx[1:0]];
          if (idx == err_at) bus_err = 1'b1;
          else               bus_ack = 1'b1;
          w = 0;
        end
      end else begin
        w = 0;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    summary();
    $finish;
  end

  initial begin
    int cnt;
    bit seen;
    logic [31:0] ssp_keep, pc_keep;
    rst_ni = 1'b0; ext_rst = 1'b0; ext_halt = 1'b0; sw_rst = 1'b0;
    mem[0] = 16'h1234; mem[1] = 16'h5678; mem[2] = 16'h9abc; mem[3] = 16'hdef0;
    push_boot();
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 bus_req", bus_req, 0);
    chk("R11 rst_out", rst_out, 0);
    chk("R11 done", done, 0);
    chk("R11 halted", halted, 0);
    chk("R11 ssp", ssp, 0);
    chk("R11 pc", pc, 0);
    chk("R11 ipl", ipl, 7);
    chk("R11 vbr", vbr, 0);

    // R8 start-up wait after power-on release
    rst_ni = 1'b1;
    for (int i = 1; i <= 3; i++) begin
      @(negedge clk);
      chk("R8 no request during start-up wait", bus_req, 0);
    end
    @(negedge clk);
    chk("R8 first request after 4 edges", bus_req, 1);
    chk("R4 ssp unchanged mid-fetch", ssp, 0);
    wait_done("R5 power-on");
    chk("R4 ssp big-endian", ssp, 32'h12345678);
    chk("R4 pc big-endian", pc, 32'h9abcdef0);
    chk("R5 ipl at done", ipl, 7);
    chk("R5 vbr at done", vbr, 0);
    @(negedge clk);
    chk("R5 done one cycle", done, 0);
    chk("R3 all four reads made", exp_q.size(), 0);

    // R6/R7 software pulse length, retrigger ignored
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      if (rst_out) cnt++;
      if (i == 50) sw_rst = 1'b1;
      if (i == 51) sw_rst = 1'b0;
      @(negedge clk);
    end
    chk("R6 R7 pulse length 124", cnt, 124);
    chk("R6 ssp kept", ssp, 32'h12345678);
    chk("R6 pc kept", pc, 32'h9abcdef0);
    chk("R6 ipl kept", ipl, 7);
    chk("R6 vbr kept", vbr, 0);

    // R1 reset without halt ignored
    seen = 0;
    ext_rst = 1'b1;
    for (int i = 0; i < 40; i++) begin
      if (i == 20) ext_rst = 1'b0;
      if (bus_req || done) seen = 1;
      @(negedge clk);
    end
    chk("R1 reset alone ignored", seen, 0);
    chk("R1 ssp kept", ssp, 32'h12345678);

    // R2 short joint assertion ignored
    seen = 0;
    ext_pulse(9, 1'b1);
    for (int i = 0; i < 20; i++) begin
      if (bus_req || done) seen = 1;
      @(negedge clk);
    end
    chk("R2 nine-edge reset ignored", seen, 0);

    // R2 qualified reset, latency 2
    mem[0] = 16'hcafe; mem[1] = 16'h0010; mem[2] = 16'h0000; mem[3] = 16'h0400;
    lat = 2;
    push_boot();
    ext_pulse(10, 1'b1);
    wait_done("R2 ten-edge reset");
    chk("R2 ssp reloaded", ssp, 32'hcafe0010);
    chk("R2 pc reloaded", pc, 32'h00000400);

    // R7 software reset while busy ignored
    mem[0] = 16'h0a0b; mem[1] = 16'h0c0d; mem[2] = 16'h0e0f; mem[3] = 16'h1011;
    lat = 3;
    push_boot();
    ext_pulse(10, 1'b1);
    for (int i = 0; i < 100 && !bus_req; i++) @(negedge clk);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    seen = 0;
    for (int i = 0; i < 200 && !done; i++) begin
      if (rst_out) seen = 1;
      @(negedge clk);
    end
    chk("R7 sw reset ignored while busy", seen, 0);
    chk("R4 ssp third load", ssp, 32'h0a0b0c0d);
    chk("R4 pc third load", pc, 32'h0e0f1011);

    // R10 reset during fetch restarts at address 0
    lat = 0;
    stall_at = 1;
    exp_q.push_back(24'h0);
    mem[0] = 16'h2222; mem[1] = 16'h3333; mem[2] = 16'h4444; mem[3] = 16'h5555;
    ext_pulse(10, 1'b1);
    repeat (20) @(negedge clk);
    chk("R10 first read served before stall", exp_q.size(), 0);
    push_boot();
    ext_pulse(10, 1'b1);
    stall_at = -1;
    wait_done("R10 restart");
    chk("R10 ssp after restart", ssp, 32'h22223333);
    chk("R10 pc after restart", pc, 32'h44445555);

    // R10 reset during software pulse ends it
    repeat (2) @(negedge clk);
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 pulse running", rst_out, 1);
    push_boot();
    ext_pulse(10, 1'b1);
    @(negedge clk);
    chk("R10 pulse cut by reset", rst_out, 0);
    wait_done("R10 after pulse");
    chk("R10 pulse stays low", rst_out, 0);

    // R9 bus error halts
    ssp_keep = ssp;
    pc_keep = pc;
    mem[0] = 16'h7777; mem[1] = 16'h8888; mem[2] = 16'h9999; mem[3] = 16'haaaa;
    err_at = 2;
    exp_q.push_back(24'h0); exp_q.push_back(24'h2); exp_q.push_back(24'h4);
    ext_pulse(10, 1'b1);
    for (int i = 0; i < 200 && !halted; i++) @(negedge clk);
    chk("R9 halted after bus error", halted, 1);
    seen = 0;
    sw_rst = 1'b1;
    @(negedge clk);
    sw_rst = 1'b0;
    for (int i = 0; i < 20; i++) begin
      if (bus_req || done || rst_out) seen = 1;
      @(negedge clk);
    end
    chk("R9 R7 quiet while halted", seen, 0);
    chk("R9 ssp unchanged", ssp, ssp_keep);
    chk("R9 pc unchanged", pc, pc_keep);
    ext_pulse(9, 1'b1);
    repeat (20) @(negedge clk);
    chk("R9 R2 short reset keeps halt", halted, 1);
    err_at = -1;
    push_boot();
    ext_pulse(10, 1'b1);
    wait_done("R9 recovery");
    chk("R9 halt cleared", halted, 0);
    chk("R9 ssp after recovery", ssp, 32'h77778888);
    chk("R9 pc after recovery", pc, 32'h9999aaaa);

    repeat (5) @(negedge clk);
    chk("R3 no reads left over", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule